// File: doc/BRIEF.md
# Linear Systolic Band Matrix-Vector Multiplier

The block forms y = A·x for an n×n band matrix A and returns the n results one at a time. A row of W identical multiply-accumulate cells does the arithmetic. W is also the number of nonzero diagonals in A. Elements of x enter at the left end and shift one cell to the right each clock. Partial sums of y start at zero, enter at the right end and shift one cell to the left each clock. Each cell reads the coefficients of one diagonal from above, and on each step it adds a·x to the partial sum passing through it.

A sequencer places x and y elements into the array on alternate cycles, so each cell does useful work every other cycle. It also selects the coefficient that each cell needs on each cycle. The operands come from flat input vectors that hold the band, stored diagonal by diagonal, and the x vector. A pulse on `start` begins a run of length n. A collector takes each finished sum as it leaves the leftmost cell and presents it with a strobe and its row index. The collector raises `done` after the last result has been presented.

Top module: `sysband_mv`

## Requirements
- R1: Each result equals the exact signed sum, over diagonals m = 0..W-1, of coefficient (m, i) times x[i+m-LOWER]. The result is AW = 2·DW + clog2(W) bits wide, two's complement.
- R2: Coefficient (m, i) is the entry of row i on diagonal m, which lies at column i+m-LOWER. It sits at `band_flat[(m·NMAX+i)·DW +: DW]`. Element x[k] sits at `x_flat[k·DW +: DW]`. Both are signed.
- R3: The following have no effect on any result: coefficients whose column falls outside 0..n-1, coefficients of rows n and above, and x elements of index n and above.
- R4: Results appear in ascending row order. Each result is shown for one cycle, with `out_valid` high and `out_idx` equal to its row. No two strobes occur on adjacent cycles.
- R5: With W=3 and LOWER=1, let start be accepted at clock edge E. Result i is visible after edge E+W+2i. Between strobes, `out_valid` is low.
- R6: A start is accepted only while no run is in progress and only when 1 ≤ n_len ≤ NMAX. Any other start produces no results and leaves `done` unchanged.
- R7: `done` clears on an accepted start. It is set in the cycle after the last result, which is W+2n-1 cycles after the start edge for W=3 and LOWER=1. It then holds until the next accepted start.
- R8: After reset, `out_valid` and `done` are low.
- R9: Full-scale operands cannot overflow the result, including the case where every operand is the most negative value.
- R10: A start given in the first cycle that `done` is high is accepted, and the run that follows is correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | asynchronous reset, active low |
| start | input | 1 | request to begin a run |
| n_len | input | NW | problem size n for the run |
| band_flat | input | W·NMAX·DW | band coefficients, stored by diagonal |
| x_flat | input | NMAX·DW | input vector x |
| out_valid | output | 1 | result strobe |
| out_idx | output | IW | row index of the presented result |
| out_y | output | AW | signed result value |
| done | output | 1 | the last result of the run has been presented |

## Verification
Every size from 1 to NMAX is run with random coefficients and random vectors. Random entries are also placed outside the band and beyond n, so a wrong meeting point between x and y, or a wrong coefficient row, shows up as a wrong sum. A run in which every in-band coefficient is zero and every stray entry is large separates correct masking at the matrix edges from accidental cancellation. A run with only one diagonal populated pins down the diagonal order and the storage layout. Full-scale runs test the accumulator width. Back-to-back runs, a start given mid-run, and starts with size 0 or NMAX+1 test the acceptance rules and the done flag.

// File: rtl/sysband_pkg.sv
package sysband_pkg;

    // Index of the token injected at cycle t when tokens go in every other
    // cycle starting at cycle off; -1 when no token belongs to that cycle.
    function automatic int slot_of(int t, int off);
        int r;
        r = t - off;
        if (r < 0 || r[0]) return -1;
        return r / 2;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sysband_cell.sv
module sysband_cell #(
    parameter int DW = 8,
    parameter int AW = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] a_in,
    input  logic                 a_vld,
    input  logic signed [DW-1:0] x_in,
    input  logic                 x_vld_in,
    input  logic signed [AW-1:0] y_in,
    input  logic                 y_vld_in,
    output logic signed [DW-1:0] x_out,
    output logic                 x_vld_out,
    output logic signed [AW-1:0] y_out,
    output logic                 y_vld_out
);
    typedef struct packed {
        logic signed [DW-1:0] x;
        logic                 xv;
        logic signed [AW-1:0] y;
        logic                 yv;
    } cell_t;

    cell_t c_d, c_q;

    always_comb begin
        logic signed [AW-1:0] a_ext, x_ext, prod;
        a_ext = {{(AW-DW){a_in[DW-1]}}, a_in};
        x_ext = {{(AW-DW){x_in[DW-1]}}, x_in};
        prod  = a_ext * x_ext;
        c_d.x  = x_in;
        c_d.xv = x_vld_in;
        c_d.yv = y_vld_in;
        c_d.y  = y_in;
        if (a_vld && x_vld_in && y_vld_in) begin
            c_d.y = y_in + prod;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign x_out     = c_q.x;
    assign x_vld_out = c_q.xv;
    assign y_out     = c_q.y;
    assign y_vld_out = c_q.yv;
endmodule

// File: rtl/sysband_seq.sv
module sysband_seq
    import sysband_pkg::*;
#(
    parameter int W     = 3,
    parameter int LOWER = 1,
    parameter int DW    = 8,
    parameter int NMAX  = 8,
    parameter int NW    = 5,
    parameter int TW    = 6,
    parameter int XOFF  = 0,
    parameter int YOFF  = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [NW-1:0]            n_len,
    input  logic [W*NMAX*DW-1:0]     band_flat,
    input  logic [NMAX*DW-1:0]       x_flat,
    output logic                     accept,
    output logic                     busy,
    output logic [NW-1:0]            n_run,
    output logic signed [DW-1:0]     x_inj,
    output logic                     x_inj_vld,
    output logic                     y_inj_vld,
    output logic [W-1:0][DW-1:0]     a_cell,
    output logic [W-1:0]             a_vld
);
    typedef struct packed {
        logic          busy;
        logic [TW-1:0] t;
        logic [NW-1:0] n;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        int tt, last_t, xs, ys, cs, row, xi;
        s_d    = s_q;
        tt     = int'(s_q.t);
        last_t = 2 * int'(s_q.n) + W - 2 + YOFF;
        accept = start && !s_q.busy && (n_len != '0) && (int'(n_len) <= NMAX);
        if (accept) begin
            s_d.busy = 1'b1;
            s_d.t    = '0;
            s_d.n    = n_len;
        end else if (s_q.busy) begin
            s_d.t = s_q.t + 1'b1;
            if (tt == last_t) s_d.busy = 1'b0;
        end

        xs        = slot_of(tt, XOFF);
        x_inj_vld = s_q.busy && (xs >= 0) && (xs < int'(s_q.n));
        xi        = x_inj_vld ? xs : 0;
        x_inj     = x_flat[xi*DW +: DW];

        ys        = slot_of(tt, YOFF);
        y_inj_vld = s_q.busy && (ys >= 0) && (ys < int'(s_q.n));

        // cell j serves diagonal W-1-j; y_i reaches it W-1-j cycles after entry
        for (int j = 0; j < W; j++) begin
            cs        = slot_of(tt, YOFF + W - 1 - j);
            a_vld[j]  = s_q.busy && (cs >= 0) && (cs < int'(s_q.n));
            row       = a_vld[j] ? cs : 0;
            a_cell[j] = band_flat[((W-1-j)*NMAX + row)*DW +: DW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy  = s_q.busy;
    assign n_run = s_q.n;
endmodule

// File: rtl/sysband_collect.sv
module sysband_collect #(
    parameter int AW = 18,
    parameter int NW = 5,
    parameter int IW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic [NW-1:0]        n_run,
    input  logic signed [AW-1:0] y_in,
    input  logic                 y_vld,
    output logic                 out_valid,
    output logic [IW-1:0]        out_idx,
    output logic signed [AW-1:0] out_y,
    output logic                 done
);
    typedef struct packed {
        logic [IW-1:0] idx;
        logic          done;
    } col_t;

    col_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        out_valid = y_vld;
        out_idx   = c_q.idx;
        out_y     = y_in;
        if (accept) begin
            c_d.idx  = '0;
            c_d.done = 1'b0;
        end else if (y_vld) begin
            c_d.idx = c_q.idx + 1'b1;
            if (int'(c_q.idx) == int'(n_run) - 1) c_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign done = c_q.done;
endmodule

// File: rtl/sysband_mv.sv
module sysband_mv
    import sysband_pkg::*;
#(
    parameter int W     = 3,
    parameter int LOWER = 1,
    parameter int DW    = 8,
    parameter int NMAX  = 8,
    localparam int AW   = 2*DW + $clog2(W),
    localparam int NW   = $clog2(NMAX+1) + 1,
    localparam int IW   = (NMAX > 1) ? $clog2(NMAX) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [NW-1:0]        n_len,
    input  logic [W*NMAX*DW-1:0] band_flat,
    input  logic [NMAX*DW-1:0]   x_flat,
    output logic                 out_valid,
    output logic [IW-1:0]        out_idx,
    output logic signed [AW-1:0] out_y,
    output logic                 done
);
    localparam int XOFF = (2*LOWER > W-1) ? 2*LOWER - (W-1) : 0;
    localparam int YOFF = XOFF + W - 1 - 2*LOWER;
    localparam int TW   = $clog2(2*NMAX + W + imax(XOFF, YOFF) + 2) + 1;

    logic                 accept, busy;
    logic [NW-1:0]        n_run;
    logic signed [DW-1:0] x_inj;
    logic                 x_inj_vld, y_inj_vld;
    logic [W-1:0][DW-1:0] a_cell;
    logic [W-1:0]         a_vld;

    logic signed [DW-1:0] x_chain  [0:W];
    logic                 xv_chain [0:W];
    logic signed [AW-1:0] y_chain  [0:W];
    logic                 yv_chain [0:W];
    logic                 unused_x_tail;

    sysband_seq #(
        .W(W), .LOWER(LOWER), .DW(DW), .NMAX(NMAX),
        .NW(NW), .TW(TW), .XOFF(XOFF), .YOFF(YOFF)
    ) i_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .n_len(n_len),
        .band_flat(band_flat), .x_flat(x_flat),
        .accept(accept), .busy(busy), .n_run(n_run),
        .x_inj(x_inj), .x_inj_vld(x_inj_vld), .y_inj_vld(y_inj_vld),
        .a_cell(a_cell), .a_vld(a_vld)
    );

    assign x_chain[0]  = x_inj;
    assign xv_chain[0] = x_inj_vld;
    assign y_chain[W]  = '0;
    assign yv_chain[W] = y_inj_vld;

    for (genvar j = 0; j < W; j++) begin : g_cell
        sysband_cell #(.DW(DW), .AW(AW)) i_cell (
            .clk(clk), .rst_n(rst_n),
            .a_in(a_cell[j]), .a_vld(a_vld[j]),
            .x_in(x_chain[j]), .x_vld_in(xv_chain[j]),
            .y_in(y_chain[j+1]), .y_vld_in(yv_chain[j+1]),
            .x_out(x_chain[j+1]), .x_vld_out(xv_chain[j+1]),
            .y_out(y_chain[j]), .y_vld_out(yv_chain[j])
        );
    end

    assign unused_x_tail = ^{x_chain[W], xv_chain[W]};

    sysband_collect #(.AW(AW), .NW(NW), .IW(IW)) i_collect (
        .clk(clk), .rst_n(rst_n), .accept(accept), .n_run(n_run),
        .y_in(y_chain[0]), .y_vld(yv_chain[0]),
        .out_valid(out_valid), .out_idx(out_idx), .out_y(out_y), .done(done)
    );
endmodule

// File: rtl/sysband_chk.sv
module sysband_chk #(
    parameter int NW = 5,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          out_valid,
    input logic [IW-1:0] out_idx,
    input logic          done,
    input logic          busy,
    input logic [NW-1:0] n_run
);
    // R4: strobes never on adjacent cycles
    a_r4_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R4: index stays inside the run
    a_r4_idx_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_idx) < int'(n_run)));

    // R4: each later result follows its predecessor two cycles earlier
    a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_idx != '0) |->
            ($past(out_valid, 2) && ($past(out_idx, 2) == out_idx - 1'b1)));

    // R7: done rises only right after the last result
    a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(out_valid) && (int'($past(out_idx)) == int'(n_run) - 1)));

    // R7: done and an active run exclude each other
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6: a start during a run does not disturb it
    a_r6_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !out_valid) |=> (busy && $stable(n_run)));

    // R8: no result outside a run
    a_r8_valid_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);
endmodule

bind sysband_mv sysband_chk #(.NW(NW), .IW(IW)) i_sysband_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .out_valid(out_valid),
    .out_idx(out_idx), .done(done), .busy(busy), .n_run(n_run)
);

// File: tb/test_sysband_mv.sv
module test_sysband_mv;
    localparam int W     = 3;
    localparam int LOWER = 1;
    localparam int DW    = 8;
    localparam int NMAX  = 8;
    localparam int AW    = 2*DW + $clog2(W);
    localparam int NW    = $clog2(NMAX+1) + 1;
    localparam int IW    = $clog2(NMAX);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [NW-1:0]        n_len = '0;
    logic [W*NMAX*DW-1:0] band_flat;
    logic [NMAX*DW-1:0]   x_flat;
    logic                 out_valid;
    logic [IW-1:0]        out_idx;
    logic signed [AW-1:0] out_y;
    logic                 done;

    int bm [W][NMAX];
    int xm [NMAX];
    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int m = 0; m < W; m++)
            for (int i = 0; i < NMAX; i++)
                band_flat[(m*NMAX+i)*DW +: DW] = DW'(bm[m][i]);
        for (int k = 0; k < NMAX; k++)
            x_flat[k*DW +: DW] = DW'(xm[k]);
    end

    sysband_mv #(.W(W), .LOWER(LOWER), .DW(DW), .NMAX(NMAX)) i_sysband_mv (
        .clk(clk), .rst_n(rst_n), .start(start), .n_len(n_len),
        .band_flat(band_flat), .x_flat(x_flat),
        .out_valid(out_valid), .out_idx(out_idx), .out_y(out_y), .done(done)
    );

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ref_y(int i, int n);
        int s = 0;
        for (int m = 0; m < W; m++) begin
            int k = i + m - LOWER;
            if (k >= 0 && k < n) s += bm[m][i] * xm[k];
        end
        return s;
    endfunction

    function automatic int rnd();
        return int'($urandom_range(255)) - 128;
    endfunction

    task automatic fill_random();
        for (int m = 0; m < W; m++)
            for (int i = 0; i < NMAX; i++) bm[m][i] = rnd();
        for (int k = 0; k < NMAX; k++) xm[k] = rnd();
    endtask

    // Called at a negedge. Starts a run of size n and follows it to cycle
    // 2n+W-1+extra after the start edge; poke=1 adds a start mid-run (R6).
    task automatic run(int n, int extra, bit poke, string tag);
        int last;
        last = 2*n + W - 1 + extra;
        n_len = NW'(n);
        start = 1'b1;
        for (int m = 0; m <= last; m++) begin
            bit ev;
            int i;
            @(negedge clk);
            ev = (m >= W) && ((m - W) % 2 == 0) && ((m - W) / 2 < n);
            i  = (m - W) / 2;
            chk("R5 out_valid timing", int'(out_valid), int'(ev));
            if (ev && out_valid) begin
                chk("R4 index", int'(out_idx), i);
                chk({tag, " result"}, int'(out_y), ref_y(i, n));
            end
            chk("R7 done", int'(done), int'(m >= 2*n + W - 1));
            if (m == 0) start = 1'b0;
            if (poke && m == 2) begin
                start = 1'b1;                  // R6: ignored while busy
                n_len = NW'((n % NMAX) + 1);
            end
            if (poke && m == 3) start = 1'b0;
        end
    endtask

    task automatic bad_start(int n);
        int d0;
        d0 = int'(done);
        n_len = NW'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 2*NMAX + W; c++) begin
            @(negedge clk);
            chk("R6 no result after rejected start", int'(out_valid), 0);
            chk("R6 done unchanged", int'(done), d0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        for (int m = 0; m < W; m++)
            for (int i = 0; i < NMAX; i++) bm[m][i] = 0;
        for (int k = 0; k < NMAX; k++) xm[k] = 0;
        repeat (3) @(negedge clk);
        chk("R8 out_valid in reset", int'(out_valid), 0);
        chk("R8 done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 out_valid after reset", int'(out_valid), 0);
        chk("R8 done after reset", int'(done), 0);

        // R1: sweep of all sizes with random data, garbage outside band
        for (int rep = 0; rep < 12; rep++)
            for (int n = 1; n <= NMAX; n++) begin
                fill_random();
                run(n, 2, 1'b0, "R1");
            end

        // R3: in-band coefficients zero, everything outside large
        for (int n = 1; n <= NMAX; n++) begin
            for (int m = 0; m < W; m++)
                for (int i = 0; i < NMAX; i++) begin
                    int k = i + m - LOWER;
                    bm[m][i] = (i < n && k >= 0 && k < n) ? 0 : 99;
                end
            for (int k = 0; k < NMAX; k++) xm[k] = (k < n) ? k + 1 : 77;
            run(n, 1, 1'b0, "R3");
        end

        // R2: one diagonal at a time, to pin down layout and order
        for (int sel = 0; sel < W; sel++) begin
            for (int m = 0; m < W; m++)
                for (int i = 0; i < NMAX; i++) bm[m][i] = (m == sel) ? i + 3 : 0;
            for (int k = 0; k < NMAX; k++) xm[k] = 10 * (k + 1);
            run(NMAX, 1, 1'b0, "R2");
        end

        // R9: full-scale operands
        for (int m = 0; m < W; m++)
            for (int i = 0; i < NMAX; i++) bm[m][i] = -128;
        for (int k = 0; k < NMAX; k++) xm[k] = -128;
        run(NMAX, 1, 1'b0, "R9");
        for (int m = 0; m < W; m++)
            for (int i = 0; i < NMAX; i++) bm[m][i] = ((i + m) % 2) ? 127 : -128;
        for (int k = 0; k < NMAX; k++) xm[k] = (k % 2) ? -128 : 127;
        run(NMAX, 1, 1'b0, "R9");

        // R10: back-to-back runs started the first cycle done is high
        for (int n = 1; n <= NMAX; n++) begin
            fill_random();
            run(n, 0, 1'b0, "R10");
        end

        // R6: start mid-run must not disturb the run in progress
        for (int n = 1; n <= NMAX; n++) begin
            fill_random();
            run(n, 1, 1'b1, "R6");
        end

        // R6: sizes outside 1..NMAX are rejected while idle
        bad_start(0);
        bad_start(NMAX + 1);
        fill_random();
        run(4, 1, 1'b0, "R6");

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule